// File: doc/BRIEF.md
# Word-to-Byte Stream Converter with Endian Select

This block sits between the 64-bit transmit and receive FIFOs of an Ethernet MAC and its PHY-side line interface. On the way out it takes one 64-bit word at a time, together with an end-of-frame flag and a valid-byte count, and plays the bytes out one per cycle on an 8-bit path (gigabit rate) or one nibble per cycle on a 4-bit path (10 and 100 Mb/s). On the way in it gathers the bytes or nibbles from the line into 64-bit words. It marks the last word of each frame and says how many bytes in that word are valid.

A byte-order input picks the lane of the word that holds the first byte on the wire. This keeps the first wire byte at the lowest memory address on both little-endian and big-endian systems. If the transmit FIFO runs dry before the end of a frame, the block stops the frame and raises an underrun pulse.

Top module: `wordstream_conv`

## Requirements
- R1: While reset is asserted and right after it, `phy_tx_en`, `tx_underrun` and `rx_word_valid` are 0 and `tx_word_ready` is 1.
- R2: In byte mode (`nibble_mode`=0), wire byte k of a word (k=0..7) comes from bits [8k+7:8k] when `big_lane`=0 and from bits [63-8k:56-8k] when `big_lane`=1. The first byte of a frame is on `phy_txd` in the cycle after the word is accepted (`tx_word_valid` and `tx_word_ready` both high at a clock edge).
- R3: In nibble mode (`nibble_mode`=1), each byte takes two cycles on `phy_txd[3:0]`, low nibble first, and `phy_txd[7:4]` is 0 while `phy_tx_en` is high.
- R4: On a word with `tx_word_last`=1, `tx_word_cnt` gives the number of valid bytes, with 0 meaning 8. Only that many bytes are sent, and `phy_tx_en` falls in the cycle after the last one. On other words `tx_word_cnt` is ignored and all 8 bytes are sent.
- R5: `tx_word_ready` is 1 when the transmitter is idle, or when the final byte (or final nibble) of a word that is not the last word is on the line, and is 0 at all other times. If the next word is valid at that point, the frame continues with no idle cycle.
- R6: If `tx_word_valid` is 0 when the final unit of a non-last word is on the line, then in the next cycle `phy_tx_en` is 0 and `tx_underrun` is 1, for exactly one cycle.
- R7: Received bytes fill lanes in the same order as R2 for the selected `big_lane`. A full word that is not the end of a frame is output with `rx_word_last`=0 and `rx_word_cnt`=0, when the next byte of the frame arrives.
- R8: When `phy_rx_dv` falls, any word holding 1 to 8 bytes is output with `rx_word_last`=1 and `rx_word_cnt` = bytes mod 8, and its unused lanes are zero. `rx_word_valid` is a one-cycle pulse in the cycle after the clock edge that sampled the completing byte or the low `phy_rx_dv`.
- R9: In nibble mode the receiver takes the low nibble first from `phy_rxd[3:0]` and ignores `phy_rxd[7:4]`. A lone nibble left over at frame end is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| nibble_mode | input | 1 | 1 = 4-bit line path, 0 = 8-bit line path |
| big_lane | input | 1 | 1 = first wire byte in bits 63:56, 0 = in bits 7:0 |
| tx_word_valid | input | 1 | Transmit FIFO holds a word |
| tx_word | input | 64 | Transmit word |
| tx_word_last | input | 1 | Word ends the frame |
| tx_word_cnt | input | 3 | Valid bytes in last word, 0 = 8 |
| tx_word_ready | output | 1 | Word is taken at this edge when valid |
| phy_tx_en | output | 1 | Line transmit data valid |
| phy_txd | output | 8 | Line transmit data (nibble on bits 3:0) |
| tx_underrun | output | 1 | One-cycle pulse: frame stopped on empty FIFO |
| phy_rx_dv | input | 1 | Line receive data valid |
| phy_rxd | input | 8 | Line receive data (nibble on bits 3:0) |
| rx_word_valid | output | 1 | Assembled word pulse |
| rx_word | output | 64 | Assembled word |
| rx_word_last | output | 1 | Word ends the frame |
| rx_word_cnt | output | 3 | Valid bytes in last word, 0 = 8 |

## Verification
A wrong byte index or nibble phase in the transmitter shows up as a swapped or repeated byte on `phy_txd` within one cycle. A wrong fill count shows up as a wrong frame length or a `tx_word_ready` pulse at the wrong place in the frame. A wrong fill count or lane pointer in the receiver shows up at the next `rx_word_valid` pulse, at most eight bytes later, as a shifted lane, a non-zero pad or a wrong `rx_word_cnt`. A word boundary off by one changes the number of words per frame. An underrun path that fails to clear the frame leaves `phy_tx_en` high in the cycle where the bench expects the pulse.

// File: rtl/wsc_pkg.sv
package wsc_pkg;
    localparam int WORD_BYTES = 8;
    localparam int WORD_W     = WORD_BYTES * 8;
    localparam int CNT_W      = $clog2(WORD_BYTES);

    typedef logic [WORD_W-1:0] word_t;
    typedef logic [CNT_W-1:0]  lane_t;
    typedef logic [CNT_W:0]    fill_t;

    typedef struct packed {
        logic  busy;
        word_t word;
        lane_t idx;
        logic  nib;
        logic  last;
        fill_t nbytes;
        logic  underrun;
    } tx_state_t;

    typedef struct packed {
        word_t      acc;
        fill_t      fill;
        logic       have_lo;
        logic [3:0] lo;
        logic       out_valid;
        word_t      out_word;
        logic       out_last;
        lane_t      out_cnt;
    } rx_state_t;

    // Position in the wire order -> byte lane of the word
    function automatic lane_t lane_of(input lane_t pos, input logic big);
        return big ? (lane_t'(WORD_BYTES - 1) - pos) : pos;
    endfunction
endpackage

// File: rtl/wsc_tx_ser.sv
module wsc_tx_ser
    import wsc_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        nibble_mode,
    input  logic        big_lane,
    input  logic        word_valid,
    input  word_t       word,
    input  logic        word_last,
    input  lane_t       word_cnt,
    output logic        word_ready,
    output logic        line_en,
    output logic [7:0]  line_data,
    output logic        underrun
);
    tx_state_t state_d, state_q;
    logic      byte_end;
    logic      word_end;
    lane_t     cur_lane;
    logic [7:0] cur_byte;
    fill_t     load_bytes;

    always_comb begin
        byte_end   = !nibble_mode || state_q.nib;
        word_end   = state_q.busy && byte_end &&
                     ({1'b0, state_q.idx} == state_q.nbytes - fill_t'(1));
        word_ready = !state_q.busy || (word_end && !state_q.last);
        load_bytes = (word_last && word_cnt != '0) ? {1'b0, word_cnt}
                                                   : fill_t'(WORD_BYTES);

        state_d          = state_q;
        state_d.underrun = 1'b0;
        if (!state_q.busy || word_end) begin
            if (state_q.busy && state_q.last) begin
                state_d.busy = 1'b0;
            end else if (word_valid) begin
                state_d.busy   = 1'b1;
                state_d.word   = word;
                state_d.idx    = '0;
                state_d.nib    = 1'b0;
                state_d.last   = word_last;
                state_d.nbytes = load_bytes;
            end else if (state_q.busy) begin
                state_d.busy     = 1'b0;
                state_d.underrun = 1'b1;
            end
        end else if (byte_end) begin
            state_d.idx = state_q.idx + lane_t'(1);
            state_d.nib = 1'b0;
        end else begin
            state_d.nib = 1'b1;
        end
    end

    always_comb begin
        cur_lane  = lane_of(state_q.idx, big_lane);
        cur_byte  = state_q.word[int'(cur_lane)*8 +: 8];
        line_en   = state_q.busy;
        underrun  = state_q.underrun;
        if (!state_q.busy)
            line_data = 8'h00;
        else if (nibble_mode)
            line_data = {4'h0, state_q.nib ? cur_byte[7:4] : cur_byte[3:0]};
        else
            line_data = cur_byte;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end
endmodule

// File: rtl/wsc_rx_pack.sv
module wsc_rx_pack
    import wsc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       nibble_mode,
    input  logic       big_lane,
    input  logic       line_dv,
    input  logic [7:0] line_data,
    output logic       word_valid,
    output word_t      word,
    output logic       word_last,
    output lane_t      word_cnt
);
    rx_state_t  state_d, state_q;
    logic       got_byte;
    logic [7:0] new_byte;
    logic       flush_full;
    word_t      base_acc;
    fill_t      base_fill;
    lane_t      put_lane;
    word_t      placed;

    // Byte assembly and the word the new byte is written into
    always_comb begin
        got_byte = 1'b0;
        new_byte = line_data;
        if (line_dv) begin
            if (!nibble_mode) begin
                got_byte = 1'b1;
            end else if (state_q.have_lo) begin
                got_byte = 1'b1;
                new_byte = {line_data[3:0], state_q.lo};
            end
        end
        flush_full = got_byte && (state_q.fill == fill_t'(WORD_BYTES));
        base_acc   = flush_full ? '0 : state_q.acc;
        base_fill  = flush_full ? '0 : state_q.fill;
        put_lane   = lane_of(base_fill[CNT_W-1:0], big_lane);
    end

    for (genvar l = 0; l < WORD_BYTES; l++) begin : g_lane
        assign placed[l*8 +: 8] = (put_lane == lane_t'(l)) ? new_byte
                                                           : base_acc[l*8 +: 8];
    end

    always_comb begin
        state_d           = state_q;
        state_d.out_valid = 1'b0;
        state_d.out_last  = 1'b0;
        if (line_dv) begin
            if (nibble_mode) begin
                state_d.have_lo = !state_q.have_lo;
                if (!state_q.have_lo) state_d.lo = line_data[3:0];
            end
            if (got_byte) begin
                if (flush_full) begin
                    state_d.out_valid = 1'b1;
                    state_d.out_word  = state_q.acc;
                    state_d.out_cnt   = '0;
                end
                state_d.acc  = placed;
                state_d.fill = base_fill + fill_t'(1);
            end
        end else begin
            state_d.have_lo = 1'b0;
            if (state_q.fill != '0) begin
                state_d.out_valid = 1'b1;
                state_d.out_last  = 1'b1;
                state_d.out_word  = state_q.acc;
                state_d.out_cnt   = state_q.fill[CNT_W-1:0];
                state_d.acc       = '0;
                state_d.fill      = '0;
            end
        end
    end

    assign word_valid = state_q.out_valid;
    assign word       = state_q.out_word;
    assign word_last  = state_q.out_last;
    assign word_cnt   = state_q.out_cnt;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end
endmodule

// File: rtl/wordstream_conv.sv
module wordstream_conv
    import wsc_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        nibble_mode,
    input  logic        big_lane,
    input  logic        tx_word_valid,
    input  logic [63:0] tx_word,
    input  logic        tx_word_last,
    input  logic [2:0]  tx_word_cnt,
    output logic        tx_word_ready,
    output logic        phy_tx_en,
    output logic [7:0]  phy_txd,
    output logic        tx_underrun,
    input  logic        phy_rx_dv,
    input  logic [7:0]  phy_rxd,
    output logic        rx_word_valid,
    output logic [63:0] rx_word,
    output logic        rx_word_last,
    output logic [2:0]  rx_word_cnt
);
    wsc_tx_ser i_tx (
        .clk        (clk),
        .rst_n      (rst_n),
        .nibble_mode(nibble_mode),
        .big_lane   (big_lane),
        .word_valid (tx_word_valid),
        .word       (tx_word),
        .word_last  (tx_word_last),
        .word_cnt   (tx_word_cnt),
        .word_ready (tx_word_ready),
        .line_en    (phy_tx_en),
        .line_data  (phy_txd),
        .underrun   (tx_underrun)
    );

    wsc_rx_pack i_rx (
        .clk        (clk),
        .rst_n      (rst_n),
        .nibble_mode(nibble_mode),
        .big_lane   (big_lane),
        .line_dv    (phy_rx_dv),
        .line_data  (phy_rxd),
        .word_valid (rx_word_valid),
        .word       (rx_word),
        .word_last  (rx_word_last),
        .word_cnt   (rx_word_cnt)
    );
endmodule

// File: rtl/wordstream_conv_chk.sv
module wordstream_conv_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       nibble_mode,
    input logic       tx_word_ready,
    input logic       phy_tx_en,
    input logic [7:0] phy_txd,
    input logic       tx_underrun,
    input logic       phy_rx_dv,
    input logic       rx_word_valid,
    input logic       rx_word_last,
    input logic [2:0] rx_word_cnt
);
    assert_idle_ready_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !phy_tx_en |-> tx_word_ready);

    assert_underrun_drop_R6: assert property (@(posedge clk) disable iff (!rst_n)
        tx_underrun |-> (!phy_tx_en && $past(phy_tx_en)));

    assert_nibble_upper_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (nibble_mode && phy_tx_en) |-> (phy_txd[7:4] == 4'h0));

    assert_full_midword_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_word_valid && !rx_word_last) |-> (rx_word_cnt == 3'd0));

    assert_word_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rx_word_valid |-> ($past(phy_rx_dv) || $past(phy_rx_dv, 2)));
endmodule

bind wordstream_conv wordstream_conv_chk i_chk (.*);

// File: tb/test_wordstream_conv.sv
`timescale 1ns/1ps
module test_wordstream_conv;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        nibble_mode = 1'b0;
    logic        big_lane = 1'b0;
    logic        tx_word_valid = 1'b0;
    logic [63:0] tx_word = '0;
    logic        tx_word_last = 1'b0;
    logic [2:0]  tx_word_cnt = '0;
    logic        tx_word_ready;
    logic        phy_tx_en;
    logic [7:0]  phy_txd;
    logic        tx_underrun;
    logic        phy_rx_dv = 1'b0;
    logic [7:0]  phy_rxd = '0;
    logic        rx_word_valid;
    logic [63:0] rx_word;
    logic        rx_word_last;
    logic [2:0]  rx_word_cnt;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    bit done   = 0;

    always #2 clk = ~clk;

    wordstream_conv i_wordstream_conv (.*);

    // {nibble, big, length, seed}
    localparam logic [17:0] VEC [8] = '{
        {1'b0, 1'b0, 8'd8,  8'h11},
        {1'b0, 1'b1, 8'd13, 8'h22},
        {1'b1, 1'b0, 8'd5,  8'h33},
        {1'b1, 1'b1, 8'd16, 8'h44},
        {1'b0, 1'b0, 8'd1,  8'h55},
        {1'b0, 1'b1, 8'd24, 8'h66},
        {1'b1, 1'b0, 8'd11, 8'h77},
        {1'b0, 1'b0, 8'd17, 8'h88}
    };

    logic [63:0] wbuf [8];
    logic [7:0]  cap  [64];
    logic [63:0] rxw  [10];
    logic        rxl  [10];
    logic [2:0]  rxc  [10];

    function automatic logic [7:0] dbyte(input logic [7:0] seed, input int i);
        return 8'(seed * 7 + i * 29 + 3);
    endfunction

    function automatic int lane(input int pos, input bit big);
        return big ? 7 - pos : pos;
    endfunction

    task automatic check(input bit ok, input string what, input logic [63:0] act,
                         input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000 && !done) begin
            fails++;
            $display("FAIL watchdog actual=%0d expected=<100000", cycles);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    task automatic run_tx(input bit nib, input bit big, input int len, input logic [7:0] seed);
        int nw = (len + 7) / 8;
        int up = nib ? 2 : 1;
        int ptr = 0, ncap = 0, units = 0, first = -1, cyc = 0;
        int bad_ready = 0, bad_upper = 0, bad_und = 0, bad_data = 0;
        bit half = 0, ended = 0, pop;
        logic [3:0] lo = '0;
        bit exp_rdy;
        for (int w = 0; w < 8; w++) wbuf[w] = '0;
        for (int i = 0; i < len; i++)
            wbuf[i/8][lane(i%8, big)*8 +: 8] = dbyte(seed, i);
        @(negedge clk);
        nibble_mode = nib;
        big_lane    = big;
        while (!ended && cyc < 400) begin
            if (cyc > 0) @(negedge clk);
            if (tx_underrun) bad_und++;
            if (phy_tx_en) begin
                units++;
                if (first < 0) first = cyc;
                exp_rdy = (units % (8*up) == 0) && (units < len*up);
                if (tx_word_ready != exp_rdy) bad_ready++;
                if (nib) begin
                    if (phy_txd[7:4] != 4'h0) bad_upper++;
                    if (!half) begin lo = phy_txd[3:0]; half = 1; end
                    else begin
                        if (ncap < 64) cap[ncap] = {phy_txd[3:0], lo};
                        ncap++; half = 0;
                    end
                end else begin
                    if (ncap < 64) cap[ncap] = phy_txd;
                    ncap++;
                end
            end else begin
                if (!tx_word_ready) bad_ready++;
                if (first >= 0) ended = 1;
            end
            tx_word_valid = (ptr < nw);
            tx_word       = wbuf[ptr < 8 ? ptr : 0];
            tx_word_last  = (ptr == nw - 1);
            tx_word_cnt   = (ptr == nw - 1) ? 3'(len % 8) : 3'd5;
            pop = tx_word_valid && tx_word_ready;
            @(posedge clk);
            if (pop) ptr++;
            cyc++;
        end
        tx_word_valid = 1'b0;
        for (int i = 0; i < len && i < ncap; i++)
            if (cap[i] != dbyte(seed, i)) bad_data++;
        check(first == 1, "R2 first byte latency", 64'(first), 64'd1);
        check(ncap == len && bad_data == 0, "R2 R4 transmitted byte order and length",
              64'(ncap * 1000 + bad_data), 64'(len * 1000));
        check(units == len * up && bad_ready == 0, "R5 ready placement and gap-free frame",
              64'(units * 1000 + bad_ready), 64'(len * up * 1000));
        check(bad_und == 0, "R6 no underrun in complete frame", 64'(bad_und), 64'd0);
        if (nib) check(bad_upper == 0, "R3 nibble upper bits zero", 64'(bad_upper), 64'd0);
    endtask

    task automatic run_rx(input bit nib, input bit big, input int len, input logic [7:0] seed,
                          input bit extra_nib);
        int nw = (len + 7) / 8;
        int got = 0;
        int steps = len * (nib ? 2 : 1) + (extra_nib ? 1 : 0);
        logic [63:0] ew;
        @(negedge clk);
        nibble_mode = nib;
        big_lane    = big;
        for (int s = 0; s < steps + 4; s++) begin
            if (s > 0) @(negedge clk);
            if (rx_word_valid) begin
                if (got < 10) begin rxw[got] = rx_word; rxl[got] = rx_word_last; rxc[got] = rx_word_cnt; end
                got++;
            end
            if (s < steps) begin
                phy_rx_dv = 1'b1;
                if (!nib) phy_rxd = dbyte(seed, s);
                else if (s % 2 == 0) phy_rxd = {4'hA, dbyte(seed, s/2)[3:0]};
                else phy_rxd = {4'h5, dbyte(seed, s/2)[7:4]};
            end else begin
                phy_rx_dv = 1'b0;
                phy_rxd   = 8'hFF;
            end
        end
        check(got == nw, "R7 R8 received word count", 64'(got), 64'(nw));
        for (int w = 0; w < nw && w < got && w < 10; w++) begin
            ew = '0;
            for (int k = 0; k < 8; k++)
                if (w*8 + k < len) ew[lane(k, big)*8 +: 8] = dbyte(seed, w*8 + k);
            check(rxw[w] == ew, nib ? "R9 R7 nibble-assembled word data" : "R7 R8 assembled word data",
                  rxw[w], ew);
            if (w == nw - 1)
                check(rxl[w] && rxc[w] == 3'(len % 8), "R8 last flag and count",
                      {rxl[w], rxc[w]}, {1'b1, 3'(len % 8)});
            else
                check(!rxl[w] && rxc[w] == 3'd0, "R7 mid-frame word full",
                      {rxl[w], rxc[w]}, 64'd0);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(!phy_tx_en && !tx_underrun && !rx_word_valid && tx_word_ready,
              "R1 state in reset", {phy_tx_en, tx_underrun, rx_word_valid, tx_word_ready},
              64'b0001);
        rst_n = 1'b1;
        @(negedge clk);
        check(!phy_tx_en && !tx_underrun && !rx_word_valid && tx_word_ready,
              "R1 state after reset", {phy_tx_en, tx_underrun, rx_word_valid, tx_word_ready},
              64'b0001);

        for (int v = 0; v < 8; v++) begin
            run_tx(VEC[v][17], VEC[v][16], int'(VEC[v][15:8]), VEC[v][7:0]);
            run_rx(VEC[v][17], VEC[v][16], int'(VEC[v][15:8]), VEC[v][7:0], 1'b0);
        end

        // R9: trailing lone nibble is discarded
        run_rx(1'b1, 1'b1, 3, 8'h9C, 1'b1);

        // R6: FIFO empty after a non-last word
        @(negedge clk);
        nibble_mode   = 1'b0;
        big_lane      = 1'b0;
        tx_word_valid = 1'b1;
        tx_word       = 64'h0807_0605_0403_0201;
        tx_word_last  = 1'b0;
        tx_word_cnt   = 3'd0;
        for (int k = 1; k <= 8; k++) begin
            @(negedge clk);
            if (k == 1) tx_word_valid = 1'b0;
            check(phy_tx_en && phy_txd == 8'(k), "R6 bytes before underrun",
                  {phy_tx_en, phy_txd}, {1'b1, 8'(k)});
        end
        @(negedge clk);
        check(!phy_tx_en && tx_underrun, "R6 underrun pulse and line idle",
              {phy_tx_en, tx_underrun}, 64'b01);
        @(negedge clk);
        check(!phy_tx_en && !tx_underrun, "R6 underrun lasts one cycle",
              {phy_tx_en, tx_underrun}, 64'b00);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule